// File: doc/BRIEF.md
# Seconds and Nanoseconds Timestamp Clock with Coherent Snapshot

This block keeps time as a pair of counts: whole seconds and nanoseconds within the current second. Both counters advance in a dedicated timer clock domain. A memory-mapped register port reads the time from a separate bus clock domain. The two clocks have no fixed phase relationship.

A host reads the time in two steps. It reads the seconds word first and then the nanoseconds word. The seconds read sends a capture request into the timer domain, where both counts are frozen in the same timer cycle. The frozen pair comes back to the bus domain through a toggle handshake. The bus read is stretched with wait-request until the pair arrives. The nanoseconds word of that same capture then stays available until the next seconds read, so the two words always belong to one instant.

Top module: `rtc_stamp_top`

## Requirements
- R1: While reset is low, both counters and the latched nanoseconds word go to zero. A nanoseconds read made before any seconds read returns 0, and wait-request is low whenever no read is pending.
- R2: The nanoseconds count rises by NS_STEP (default 8) on every timer clock. It is always a multiple of NS_STEP and always below NS_WRAP.
- R3: When the nanoseconds count would reach NS_WRAP, it returns to 0 and the seconds count rises by one on the same timer edge. At no other time does the seconds count change.
- R4: A read at offset 0 returns the seconds count captured in the timer domain. In the same timer cycle it captures the nanoseconds count, so seconds*NS_WRAP+nanoseconds tracks the time elapsed since reset.
- R5: A read at offset 1 returns the latched nanoseconds word of the last seconds read. Repeated offset-1 reads return the same value until the next offset-0 read.
- R6: For two successive seconds/nanoseconds pairs, the combined value rises strictly. The change in the combined value equals the elapsed time, to within the synchronisation jitter.
- R7: An offset-1 read holds wait-request high for exactly one bus cycle. An offset-0 read holds it high until the captured pair has crossed back, which takes between 3 and 12 bus cycles with two-stage synchronisers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmr_clk_i | input | 1 | Timer clock, nominally 125 MHz |
| bus_clk_i | input | 1 | Register port clock, nominally 100 MHz |
| rst_ni | input | 1 | Active-low asynchronous reset, shared by both domains |
| bus_read_i | input | 1 | Read strobe, held until wait-request drops |
| bus_addr_i | input | ADDR_W | Word offset: 0 selects seconds, 1 selects nanoseconds |
| bus_rdata_o | output | DATA_W | Read data, valid while read is high and wait-request is low |
| bus_waitreq_o | output | 1 | Stalls the current read |

## Verification
The embedded assertions check the following on every clock:
- the nanoseconds step and range;
- the seconds increment tied to the wrap;
- that a capture acknowledge only follows a detected request;
- that a request toggle only starts from an idle seconds read;
- that an acknowledge only arrives while the port is waiting.

What the assertions cannot see is whether a returned pair is coherent and matches real elapsed time across the asynchronous boundary. The bench covers this by comparing each pair's combined value against its own clock. It also checks that repeated nanoseconds reads stay stable, and it measures the wait-request lengths directly. Most of these read sequences use a shortened second so that many wraps occur.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_WAIT = 2'd1,
    BUS_RESP = 2'd2
  } bus_state_e;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int DATA_W  = 32,
  parameter int NS_STEP = 8,
  parameter int NS_WRAP = 1_000_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] ns_o
);
  localparam logic [DATA_W-1:0] STEP_L = DATA_W'(NS_STEP);
  localparam logic [DATA_W-1:0] WRAP_L = DATA_W'(NS_WRAP);
  localparam logic [DATA_W-1:0] LAST_L = DATA_W'(NS_WRAP - NS_STEP);

  logic [DATA_W-1:0] sec_q, ns_q;
  logic              at_last;

  assign at_last = (ns_q == LAST_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (at_last) begin
      sec_q <= sec_q + 1'b1;
      ns_q  <= '0;
    end else begin
      ns_q  <= ns_q + STEP_L;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;

  // R2
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_q < WRAP_L);

  // R2
  ns_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_q != '0) |-> (ns_q == $past(ns_q) + STEP_L));

  // R3
  wrap_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_q == '0 && $past(ns_q) == LAST_L) |-> (sec_q == $past(sec_q) + 1'b1));

  // R3
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_q != '0) |-> $stable(sec_q));
endmodule

// File: rtl/rtc_capture.sv
module rtc_capture #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [DATA_W-1:0] sec_i,
  input  logic [DATA_W-1:0] ns_i,
  output logic [DATA_W-1:0] snap_sec_o,
  output logic [DATA_W-1:0] snap_ns_o,
  output logic              ack_tgl_o
);
  logic req_s, req_d, req_edge, ack_q;
  logic [DATA_W-1:0] snap_sec_q, snap_ns_q;

  rtc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  assign req_edge = req_s ^ req_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d      <= 1'b0;
      ack_q      <= 1'b0;
      snap_sec_q <= '0;
      snap_ns_q  <= '0;
    end else begin
      req_d <= req_s;
      if (req_edge) begin
        // both words from one timer cycle
        snap_sec_q <= sec_i;
        snap_ns_q  <= ns_i;
        ack_q      <= ~ack_q;
      end
    end
  end

  assign snap_sec_o = snap_sec_q;
  assign snap_ns_o  = snap_ns_q;
  assign ack_tgl_o  = ack_q;

  // R4
  ack_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q != $past(ack_q)) |-> $past(req_s != req_d));
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              waitreq_o,
  output logic              req_tgl_o,
  input  logic              ack_tgl_i,
  input  logic [DATA_W-1:0] snap_sec_i,
  input  logic [DATA_W-1:0] snap_ns_i
);
  localparam logic [ADDR_W-1:0] NS_OFF = ADDR_W'(1);

  bus_state_e        state_q;
  logic              ack_s, ack_d, ack_edge, req_q;
  logic [DATA_W-1:0] ns_hold_q, rdata_q;

  rtc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_i),
    .q_o   (ack_s)
  );

  assign ack_edge = ack_s ^ ack_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= BUS_IDLE;
      ack_d     <= 1'b0;
      req_q     <= 1'b0;
      ns_hold_q <= '0;
      rdata_q   <= '0;
    end else begin
      ack_d <= ack_s;
      unique case (state_q)
        BUS_IDLE: if (read_i) begin
          if (addr_i == NS_OFF) begin
            rdata_q <= ns_hold_q;
            state_q <= BUS_RESP;
          end else begin
            req_q   <= ~req_q;
            state_q <= BUS_WAIT;
          end
        end
        BUS_WAIT: if (ack_edge) begin
          // timer-side snapshot is static until the next request
          rdata_q   <= snap_sec_i;
          ns_hold_q <= snap_ns_i;
          state_q   <= BUS_RESP;
        end
        BUS_RESP: state_q <= BUS_IDLE;
        default:  state_q <= BUS_IDLE;
      endcase
    end
  end

  assign waitreq_o = read_i && (state_q != BUS_RESP);
  assign rdata_o   = rdata_q;
  assign req_tgl_o = req_q;

  // R7
  ack_when_waiting_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_edge |-> (state_q == BUS_WAIT));

  // R4
  req_from_sec_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != $past(req_q)) |-> $past(state_q == BUS_IDLE && read_i && addr_i != NS_OFF));

  // R5
  ns_hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_hold_q != $past(ns_hold_q)) |-> ($past(state_q) == BUS_WAIT && state_q == BUS_RESP));

  // R7
  resp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_RESP) |=> (state_q == BUS_IDLE));
endmodule

// File: rtl/rtc_stamp_top.sv
module rtc_stamp_top #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 1,
  parameter int NS_STEP     = 8,
  parameter int NS_WRAP     = 1_000_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tmr_clk_i,
  input  logic              bus_clk_i,
  input  logic              rst_ni,
  input  logic              bus_read_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_waitreq_o
);
  logic [DATA_W-1:0] cnt_sec, cnt_ns, snap_sec, snap_ns;
  logic              req_tgl, ack_tgl;

  rtc_counter #(
    .DATA_W (DATA_W),
    .NS_STEP(NS_STEP),
    .NS_WRAP(NS_WRAP)
  ) u_counter (
    .clk_i (tmr_clk_i),
    .rst_ni(rst_ni),
    .sec_o (cnt_sec),
    .ns_o  (cnt_ns)
  );

  rtc_capture #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_capture (
    .clk_i     (tmr_clk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl),
    .sec_i     (cnt_sec),
    .ns_i      (cnt_ns),
    .snap_sec_o(snap_sec),
    .snap_ns_o (snap_ns),
    .ack_tgl_o (ack_tgl)
  );

  rtc_bus_if #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_bus_if (
    .clk_i     (bus_clk_i),
    .rst_ni    (rst_ni),
    .read_i    (bus_read_i),
    .addr_i    (bus_addr_i),
    .rdata_o   (bus_rdata_o),
    .waitreq_o (bus_waitreq_o),
    .req_tgl_o (req_tgl),
    .ack_tgl_i (ack_tgl),
    .snap_sec_i(snap_sec),
    .snap_ns_i (snap_ns)
  );
endmodule

// File: tb/rtc_stamp_top_test.sv
`timescale 1ns/1ps
module rtc_stamp_top_test;
  localparam int WRAP = 1000;
  localparam int STEP = 8;
  localparam longint T_REL = 50;

  logic        tmr_clk = 1'b0;
  logic        bus_clk = 1'b0;
  logic        rst_ni  = 1'b0;
  logic        rd      = 1'b0;
  logic [0:0]  addr    = 1'b0;
  logic [31:0] rdata;
  logic        waitreq;

  int vectors  = 0;
  int failures = 0;
  bit finished = 0;

  always #4 tmr_clk = ~tmr_clk;
  always #5 bus_clk = ~bus_clk;

  rtc_stamp_top #(
    .DATA_W(32), .ADDR_W(1), .NS_STEP(STEP), .NS_WRAP(WRAP), .SYNC_STAGES(2)
  ) uut (
    .tmr_clk_i    (tmr_clk),
    .bus_clk_i    (bus_clk),
    .rst_ni       (rst_ni),
    .bus_read_i   (rd),
    .bus_addr_i   (addr),
    .bus_rdata_o  (rdata),
    .bus_waitreq_o(waitreq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d, output int lat, output longint t0);
    @(negedge bus_clk);
    rd = 1'b1; addr = a; lat = 0; t0 = $time;
    do begin
      @(posedge bus_clk); #1;
      lat++;
    end while (waitreq && lat < 100);
    d = rdata;
    @(negedge bus_clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge bus_clk);
  endtask

  initial begin
    logic [31:0] sec, ns, ns2;
    int lat;
    longint t0, tot, prev_tot, prev_t0, dt_dummy;
    logic [31:0] prev_sec;
    #T_REL rst_ni = 1'b1;
    idle(4);
    // R1: idle wait-request and cleared latched word
    chk(waitreq == 1'b0, "R1 waitreq idle", waitreq, 0);
    bus_read(1'b1, ns, lat, dt_dummy);
    chk(ns == 0, "R1 ns before capture", ns, 0);
    chk(lat == 1, "R7 ns read latency", lat, 1);
    prev_tot = 0; prev_t0 = 0; prev_sec = 0;
    for (int i = 0; i < 200; i++) begin
      idle((i * 13) % 37);
      bus_read(1'b0, sec, lat, t0);
      chk(lat >= 3 && lat <= 12, "R7 sec read latency", lat, 7);
      bus_read(1'b1, ns, lat, dt_dummy);
      chk(lat == 1, "R7 ns read latency", lat, 1);
      idle(i % 5);
      bus_read(1'b1, ns2, lat, dt_dummy);
      chk(ns2 == ns, "R5 ns stable", ns2, ns);
      chk(ns < WRAP, "R2 ns range", ns, WRAP - STEP);
      chk(ns % STEP == 0, "R2 ns step multiple", ns % STEP, 0);
      chk(sec - prev_sec <= 1, "R3 seconds carry", sec - prev_sec, prev_sec + 1);
      tot = longint'(sec) * WRAP + longint'(ns);
      if (i == 0) begin
        // R4: absolute value against time since reset release
        chk((tot - (t0 - T_REL)) >= -8 && (tot - (t0 - T_REL)) <= 64,
            "R4 absolute time", tot, t0 - T_REL + 24);
      end else begin
        chk(tot > prev_tot, "R6 monotonic", tot, prev_tot + 1);
        chk((tot - prev_tot) - (t0 - prev_t0) >= -32 && (tot - prev_tot) - (t0 - prev_t0) <= 32,
            "R6 elapsed delta", tot - prev_tot, t0 - prev_t0);
      end
      chk(waitreq == 1'b0, "R1 waitreq idle", waitreq, 0);
      prev_tot = tot; prev_t0 = t0; prev_sec = sec;
    end
    chk(prev_sec >= 20, "R3 seconds reached", prev_sec, 20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      vectors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end
endmodule